// File: doc/BRIEF.md
# Fuse Row Reader with Key-Region Read Protection

This unit serves row reads from a one-time-programmable fuse array. A read request carries a packed address made of a page number and a row number. For each request the unit returns one 32-bit row into a capture register. It also gives a one-cycle completion pulse to the interrupt logic. A fixed window of rows on page 0 holds secret key material. A read that lands in that window never reaches the array. It returns zero and pulses an error indication together with completion. Keeping that error sticky is the job of the interrupt logic downstream.

The request side is a valid/ready stream with one transfer in flight. `req_ready` is high only while the unit is idle. A request that is offered while the unit is busy waits, and the requester must hold `req_valid` and `req_addr` stable until a cycle in which ready is high. The array side is a simple fetch handshake. `arr_req` stays high with a stable `arr_addr` until the array answers with a one-cycle `arr_valid`. There is no back-pressure on the result pulses.

Top module: `fuse_row_reader`

## Requirements
- R1: The request address packs the page in bits 16:13 and the row in bits 12:5. Bits 4:0 are ignored. For an allowed read, `arr_addr` is presented as {page, row}, with the page in bits 11:8 and the row in bits 7:0, and it holds stable while `arr_req` is high.
- R2: Page 0, rows 12 to 35 inclusive, are read-blocked. An accepted request to any of these rows never raises `arr_req`.
- R3: A blocked read loads 0 into `rd_data` and pulses `rd_err` and `rd_done` together. The pulses appear in the cycle after the request is accepted.
- R4: An allowed read loads `arr_data` into `rd_data` on the edge where `arr_valid` is seen with `arr_req` high. `rd_done` pulses in the following cycle and `rd_err` stays low.
- R5: Every accepted request produces exactly one `rd_done` pulse.
- R6: `rd_data` changes only in a cycle where `rd_done` is high. Between reads it holds its value.
- R7: `req_ready` is high only when no array fetch is outstanding. A request offered while busy is not accepted until the fetch completes. A blocked read leaves the unit idle, so back-to-back blocked reads are accepted on consecutive cycles.
- R8: `arr_req` is raised in the cycle after an allowed request is accepted and stays high until `arr_valid` is sampled. An `arr_valid` that arrives while `arr_req` is low is ignored.
- R9: After reset, `req_ready` is 1, and `arr_req`, `rd_done`, `rd_err` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Unit idle, request will be accepted |
| req_addr | input | 17 | Packed address: page 16:13, row 12:5, bits 4:0 ignored |
| arr_req | output | 1 | Array fetch outstanding |
| arr_addr | output | 12 | Array row address {page, row} |
| arr_valid | input | 1 | Array row data valid (one cycle) |
| arr_data | input | 32 | Array row data |
| rd_data | output | 32 | Captured read result |
| rd_done | output | 1 | Read completion pulse |
| rd_err | output | 1 | Blocked-read pulse |

## Verification
Suppose the decode window is off by one row, for example the comparison at row 12 or row 35 is wrong. Then at the next accepted read of that boundary row, `arr_req` rises when it should not, or fails to rise when it should. The per-cycle reference comparison reports this one cycle after acceptance. A wrong control state shows at the ports as soon as it happens. Examples are losing the busy state or leaving it early: `req_ready` and `arr_req` disagree with the model in that same cycle. A capture register that updates without completion shows up after a stray `arr_valid` arrives while idle. A missing or duplicated completion pulse shows up in the done-versus-accept tally at the end, and also in the cycle-by-cycle `rd_done` comparison.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rd_state_e;
endpackage

// File: rtl/fuse_rd_decode.sv
// Splits the packed request address and flags the protected key window.
module fuse_rd_decode #(
  parameter int PAGE_W    = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 5,
  parameter int BLK_PAGE  = 0,
  parameter int BLK_FIRST = 12,
  parameter int BLK_LAST  = 35,
  localparam int ADDR_W   = PAGE_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PAGE_W-1:0] page,
  output logic [ROW_W-1:0]  row,
  output logic              blocked
);
  assign page = addr[ADDR_W-1 -: PAGE_W];
  assign row  = addr[COL_W +: ROW_W];

  always_comb begin
    blocked = (page == PAGE_W'(BLK_PAGE)) &&
              ({1'b0, row} >= (ROW_W+1)'(BLK_FIRST)) &&
              ({1'b0, row} <= (ROW_W+1)'(BLK_LAST));
  end
endmodule

// File: rtl/fuse_rd_ctrl.sv
// Request acceptance, array fetch handshake and completion pulses.
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int PAGE_W  = 4,
  parameter int ROW_W   = 8,
  localparam int AADR_W = PAGE_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] page,
  input  logic [ROW_W-1:0]  row,
  input  logic              blocked,
  output logic              arr_req,
  output logic [AADR_W-1:0] arr_addr,
  input  logic              arr_valid,
  output logic              ld_en,
  output logic              ld_zero,
  output logic              done,
  output logic              err
);
  rd_state_e state;
  logic      accept;

  assign req_ready = (state == ST_IDLE);
  assign arr_req   = (state == ST_WAIT);
  assign accept    = req_valid && req_ready;
  assign ld_zero   = (state == ST_IDLE);
  assign ld_en     = (accept && blocked) || (arr_req && arr_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      arr_addr <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (blocked) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              state    <= ST_WAIT;
              arr_addr <= {page, row};
            end
          end
        end
        ST_WAIT: begin
          if (arr_valid) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_valid |=> arr_req) else $error("fetch dropped early"); // R8
  AST_FETCH_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_valid |=> $stable(arr_addr)) else $error("fetch address moved"); // R1
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> !req_ready) else $error("ready while busy"); // R7
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done) else $error("error without done"); // R3
endmodule

// File: rtl/fuse_rd_datareg.sv
// Read-only capture register for the returned row.
module fuse_rd_datareg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              ld_zero,
  input  logic [DATA_W-1:0] ld_val,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (ld_en) q <= ld_zero ? '0 : ld_val;
  end
endmodule

// File: rtl/fuse_row_reader.sv
module fuse_row_reader #(
  parameter int PAGE_W    = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 5,
  parameter int DATA_W    = 32,
  parameter int BLK_PAGE  = 0,
  parameter int BLK_FIRST = 12,
  parameter int BLK_LAST  = 35,
  localparam int ADDR_W   = PAGE_W + ROW_W + COL_W,
  localparam int AADR_W   = PAGE_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              arr_req,
  output logic [AADR_W-1:0] arr_addr,
  input  logic              arr_valid,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic              rd_err
);
  logic [PAGE_W-1:0] dec_page;
  logic [ROW_W-1:0]  dec_row;
  logic              dec_blocked;
  logic              ld_en;
  logic              ld_zero;

  fuse_rd_decode #(
    .PAGE_W(PAGE_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .BLK_PAGE(BLK_PAGE), .BLK_FIRST(BLK_FIRST), .BLK_LAST(BLK_LAST)
  ) u_dec (
    .addr(req_addr), .page(dec_page), .row(dec_row), .blocked(dec_blocked)
  );

  fuse_rd_ctrl #(.PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .page(dec_page), .row(dec_row), .blocked(dec_blocked),
    .arr_req(arr_req), .arr_addr(arr_addr), .arr_valid(arr_valid),
    .ld_en(ld_en), .ld_zero(ld_zero), .done(rd_done), .err(rd_err)
  );

  fuse_rd_datareg #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_zero(ld_zero),
    .ld_val(arr_data), .q(rd_data)
  );

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> $stable(rd_data)) else $error("data changed without done"); // R6
  AST_BLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_data == '0)) else $error("blocked read leaked data"); // R3
  AST_NO_FETCH_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> !((arr_addr[AADR_W-1 -: PAGE_W] == PAGE_W'(BLK_PAGE)) &&
                  ({1'b0, arr_addr[ROW_W-1:0]} >= (ROW_W+1)'(BLK_FIRST)) &&
                  ({1'b0, arr_addr[ROW_W-1:0]} <= (ROW_W+1)'(BLK_LAST))))
    else $error("protected row fetched"); // R2
endmodule

// File: tb/tb_fuse_row_reader.sv
`timescale 1ns/1ps
module tb_fuse_row_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic        arr_req;
  logic [11:0] arr_addr;
  logic        arr_valid = 1'b0;
  logic [31:0] arr_data = '0;
  logic [31:0] rd_data;
  logic        rd_done;
  logic        rd_err;

  always #5 clk = ~clk;

  fuse_row_reader dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .arr_req(arr_req), .arr_addr(arr_addr),
    .arr_valid(arr_valid), .arr_data(arr_data), .rd_data(rd_data),
    .rd_done(rd_done), .rd_err(rd_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_accept = 0;
  int n_done = 0;
  int fetch_cycles = 0;
  int lat_cfg = 0;
  int wcnt = 0;
  bit spur = 1'b0;
  bit finished = 1'b0;

  function automatic logic [31:0] fuse_row(input logic [3:0] p, input logic [7:0] r);
    return {4'hA, p, r, ~r, 8'h5C};
  endfunction

  function automatic bit in_window(input logic [3:0] p, input logic [7:0] r);
    return (p == 4'd0) && (r >= 8'd12) && (r <= 8'd35);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_busy = 0;
  logic [11:0] m_addr = '0;
  logic [31:0] m_data = '0;
  bit          m_done = 0;
  bit          m_err = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_addr <= '0; m_data <= '0; m_done <= 0; m_err <= 0;
    end else begin
      m_done <= 0;
      m_err  <= 0;
      if (!m_busy && req_valid) begin
        n_accept++;
        if (in_window(req_addr[16:13], req_addr[12:5])) begin
          m_data <= '0; m_done <= 1; m_err <= 1;
        end else begin
          m_busy <= 1; m_addr <= {req_addr[16:13], req_addr[12:5]};
        end
      end else if (m_busy && arr_valid) begin
        m_data <= arr_data; m_done <= 1; m_busy <= 0;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 req_ready", {31'd0, req_ready}, {31'd0, !m_busy});
      chk("R8 arr_req", {31'd0, arr_req}, {31'd0, m_busy});
      if (m_busy) chk("R1 arr_addr", {20'd0, arr_addr}, {20'd0, m_addr});
      chk("R6 rd_data", rd_data, m_data);
      chk("R5 rd_done", {31'd0, rd_done}, {31'd0, m_done});
      chk("R3 rd_err", {31'd0, rd_err}, {31'd0, m_err});
      if (rd_done) n_done++;
      if (arr_req) fetch_cycles++;
    end
  end

  // Array model with configurable latency
  always @(negedge clk) begin
    if (arr_req) begin
      if (wcnt >= lat_cfg) begin
        arr_valid = 1'b1;
        arr_data  = fuse_row(arr_addr[11:8], arr_addr[7:0]);
        wcnt = 0;
      end else begin
        arr_valid = 1'b0;
        wcnt++;
      end
    end else if (spur) begin
      arr_valid = 1'b1;
      arr_data  = 32'hDEAD_BEEF;
    end else begin
      arr_valid = 1'b0;
      wcnt = 0;
    end
  end

  task automatic do_read(input logic [3:0] p, input logic [7:0] r,
                         input logic [4:0] junk, input int lat, input string tag);
    int fc0;
    lat_cfg = lat;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {p, r, junk};
    while (!req_ready) @(negedge clk);
    fc0 = fetch_cycles;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rd_done) @(negedge clk);
    if (in_window(p, r)) begin
      chk({tag, " R3 blocked data"}, rd_data, 32'd0);
      chk({tag, " R3 blocked err"}, {31'd0, rd_err}, 32'd1);
      chk({tag, " R2 no fetch"}, fetch_cycles, fc0);
    end else begin
      chk({tag, " R4 row data"}, rd_data, fuse_row(p, r));
      chk({tag, " R4 no err"}, {31'd0, rd_err}, 32'd0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R9 reset arr_req", {31'd0, arr_req}, 32'd0);
    chk("R9 reset data", rd_data, 32'd0);
    chk("R9 reset done/err", {30'd0, rd_done, rd_err}, 32'd0);

    do_read(4'd0, 8'd0, 5'd0, 0, "p0r0");
    do_read(4'd0, 8'd11, 5'h1F, 2, "R2 edge r11");
    do_read(4'd0, 8'd12, 5'd0, 1, "R2 edge r12");
    do_read(4'd0, 8'd35, 5'h15, 1, "R2 edge r35");
    do_read(4'd0, 8'd36, 5'h0A, 3, "R1 r36 junk col");
    do_read(4'd1, 8'd20, 5'd0, 0, "R1 page1 r20");
    do_read(4'd15, 8'd255, 5'h1F, 4, "R1 top");
    do_read(4'd0, 8'd20, 5'd3, 0, "R2 mid key");

    // stray array response while idle must not touch the data register
    held = rd_data;
    @(negedge clk); spur = 1'b1;
    repeat (3) @(negedge clk);
    spur = 1'b0;
    @(negedge clk);
    chk("R8 stray valid ignored", rd_data, held);

    // back-to-back blocked requests are accepted on consecutive cycles
    @(negedge clk);
    req_valid = 1'b1; req_addr = {4'd0, 8'd13, 5'd0};
    @(negedge clk);
    chk("R7 back-to-back ready", {31'd0, req_ready}, 32'd1);
    req_addr = {4'd0, 8'd30, 5'd0};
    @(negedge clk);
    req_valid = 1'b0;

    // long fetch with a second request waiting on back-pressure
    lat_cfg = 6;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {4'd2, 8'd40, 5'd0};
    @(negedge clk);
    req_addr = {4'd3, 8'd7, 5'd0};
    chk("R7 busy not ready", {31'd0, req_ready}, 32'd0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rd_done) @(negedge clk);
    chk("R4 queued read data", rd_data, fuse_row(4'd3, 8'd7));

    repeat (4) @(negedge clk);
    chk("R5 one done per accept", n_done, n_accept);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule